// File: doc/BRIEF.md
# Display Line FIFO Refill Requester

This block decides when and how much pixel data to fetch from memory into a word-wide display line FIFO. It watches the FIFO occupancy reported by the FIFO. When the number of stored words drops to a programmable trigger level, it raises a burst read request. The request carries a word count and a start address.

A single mode input selects how long each burst is.
- In fixed mode the burst is the high-mark setting.
- In dynamic mode the burst tops the FIFO up until the number of empty words is the high mark minus two.

In both modes the length is trimmed so that the FIFO cannot overflow and a burst never crosses the end of the frame.

The fetch address starts at a programmable frame base. It steps by one per delivered word and returns to the frame base after a frame's worth of words. Only one burst is in flight at a time. The next trigger is considered only after the last word of the current burst has been written.

Top module: `pixfetch_req`

## Requirements
- R1: After reset `req_valid` is 0, and the first request carries `req_addr` equal to `frame_base`.
- R2: While no burst is pending or in transfer, a request is raised on the clock edge after `fifo_level <= trig_mark` is seen. While `fifo_level > trig_mark` no request is raised.
- R3: With `mode_fixed` = 1, `req_len` is the smallest of `high_mark`, `DEPTH - fifo_level` and the words left in the frame.
- R4: With `mode_fixed` = 0, `req_len` is the smaller of two values: `DEPTH - fifo_level - max(high_mark - 2, 0)` and the words left in the frame.
- R5: When the computed length is zero or less, no request is raised.
- R6: `req_valid`, `req_len` and `req_addr` stay unchanged while `req_ready` is low. `req_valid` drops on the edge after it is sampled with `req_ready` high.
- R7: From acceptance until the `req_len`-th `word_wr` pulse, no new request is raised, whatever `fifo_level` is. `word_wr` pulses outside a transfer do not move the fetch address.
- R8: The fetch address advances by one per transferred word. After `frame_len` words it reloads `frame_base`, using the value present at that wrap. The next request starts at the advanced address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_level | input | LVL_W | Words currently held in the line FIFO (0..DEPTH) |
| mode_fixed | input | 1 | 1 = fixed-length bursts, 0 = dynamic top-up |
| high_mark | input | LVL_W | High-mark setting |
| trig_mark | input | LVL_W | Trigger level for starting a burst |
| frame_base | input | ADDR_W | Word address of the first frame word |
| frame_len | input | FLEN_W | Words per frame (at least 1) |
| req_ready | input | 1 | Memory side accepts the pending request |
| word_wr | input | 1 | One burst word written into the FIFO this cycle |
| req_valid | output | 1 | Burst request pending |
| req_len | output | LVL_W | Burst length in words |
| req_addr | output | ADDR_W | Word address of the first word of the burst |

## Verification
The bench builds the block with DEPTH = 16, ADDR_W = 16 and FLEN_W = 16, and drives `frame_len` = 23. A 16-word FIFO lets random levels span everything from empty to full, so the clamp to free space, the zero-length dynamic case and high marks below two all come up often. The short odd frame forces the address to wrap every few bursts, and bursts are often trimmed at the frame end. A change of `frame_base` in mid-run checks that the new base is picked up at the next wrap.

// File: rtl/pixfetch_pkg.sv
// Shared types for the display line FIFO refill requester.
package pixfetch_pkg;
    // Controller phases: waiting for trigger, request pending, words arriving.
    typedef enum logic [1:0] {
        PF_IDLE = 2'd0,
        PF_REQ  = 2'd1,
        PF_XFER = 2'd2
    } pf_state_e;
endpackage

// File: rtl/pixfetch_len.sv
// Burst length calculator.
// Computes the burst length from FIFO occupancy, mode and marks. The length
// is trimmed to the free FIFO space and to the words left before frame end.
// Assumes level <= DEPTH and FLEN_W >= LVL_W. Purely combinational.
module pixfetch_len #(
    parameter int DEPTH  = 16,
    parameter int LVL_W  = 5,
    parameter int FLEN_W = 16
) (
    input  logic [LVL_W-1:0]  level,
    input  logic [LVL_W-1:0]  high_mark,
    input  logic              mode_fixed,
    input  logic [FLEN_W-1:0] frm_left,
    output logic [LVL_W-1:0]  burst_len
);
    localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

    logic [LVL_W-1:0] free_w;
    logic [LVL_W-1:0] keep_w;
    logic [LVL_W-1:0] fix_len;
    logic [LVL_W-1:0] dyn_len;
    logic [LVL_W-1:0] raw_len;

    // Derive both mode lengths, select one, then trim to the frame end.
    always_comb begin
        free_w    = DEPTH_L - level;
        keep_w    = (high_mark >= LVL_W'(2)) ? high_mark - LVL_W'(2) : '0;
        fix_len   = (high_mark < free_w) ? high_mark : free_w;
        dyn_len   = (free_w > keep_w) ? free_w - keep_w : '0;
        raw_len   = mode_fixed ? fix_len : dyn_len;
        burst_len = (frm_left < FLEN_W'(raw_len)) ? frm_left[LVL_W-1:0] : raw_len;
    end
endmodule

// File: rtl/pixfetch_addr.sv
// Fetch address generator.
// Holds the next word address and the number of words left in the frame.
// Each step advances by one word. The last word of a frame reloads the
// current frame_base and frame_len. Assumes frame_len >= 1.
module pixfetch_addr #(
    parameter int ADDR_W = 16,
    parameter int FLEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] frame_base,
    input  logic [FLEN_W-1:0] frame_len,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [FLEN_W-1:0] frm_left
);
    // Advance or wrap the address once per transferred word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= frame_base;
            frm_left <= frame_len;
        end else if (step) begin
            if (frm_left == FLEN_W'(1)) begin
                cur_addr <= frame_base;
                frm_left <= frame_len;
            end else begin
                cur_addr <= cur_addr + ADDR_W'(1);
                frm_left <= frm_left - FLEN_W'(1);
            end
        end
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cur_addr)); // R7
    AST_LEFT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        frm_left != '0); // R8
endmodule

// File: rtl/pixfetch_req.sv
// Display line FIFO refill requester (top).
// Raises one burst read request at a time when the FIFO level falls to the
// trigger mark. It holds the request until it is accepted, then counts the
// delivered words before looking at the trigger again.
// Assumes the memory side writes words only after accepting the request.
module pixfetch_req
    import pixfetch_pkg::*;
#(
    parameter int  DEPTH  = 16,
    parameter int  ADDR_W = 16,
    parameter int  FLEN_W = 16,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              mode_fixed,
    input  logic [LVL_W-1:0]  high_mark,
    input  logic [LVL_W-1:0]  trig_mark,
    input  logic [ADDR_W-1:0] frame_base,
    input  logic [FLEN_W-1:0] frame_len,
    input  logic              req_ready,
    input  logic              word_wr,
    output logic              req_valid,
    output logic [LVL_W-1:0]  req_len,
    output logic [ADDR_W-1:0] req_addr
);
    localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

    pf_state_e         st;
    logic [LVL_W-1:0]  remain;
    logic [LVL_W-1:0]  calc_len;
    logic [ADDR_W-1:0] cur_addr;
    logic [FLEN_W-1:0] frm_left;
    logic              step;

    // A word moves the address only while a burst is in transfer.
    assign step = word_wr && (st == PF_XFER);

    pixfetch_len #(.DEPTH(DEPTH), .LVL_W(LVL_W), .FLEN_W(FLEN_W)) u_len (
        .level      (fifo_level),
        .high_mark  (high_mark),
        .mode_fixed (mode_fixed),
        .frm_left   (frm_left),
        .burst_len  (calc_len)
    );

    pixfetch_addr #(.ADDR_W(ADDR_W), .FLEN_W(FLEN_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_base (frame_base),
        .frame_len  (frame_len),
        .step       (step),
        .cur_addr   (cur_addr),
        .frm_left   (frm_left)
    );

    // Request and transfer sequencing with one burst outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= PF_IDLE;
            req_valid <= 1'b0;
            req_len   <= '0;
            req_addr  <= '0;
            remain    <= '0;
        end else begin
            case (st)
                PF_IDLE: begin
                    if (fifo_level <= trig_mark && calc_len != '0) begin
                        req_valid <= 1'b1;
                        req_len   <= calc_len;
                        req_addr  <= cur_addr;
                        st        <= PF_REQ;
                    end
                end
                PF_REQ: begin
                    if (req_ready) begin
                        req_valid <= 1'b0;
                        remain    <= req_len;
                        st        <= PF_XFER;
                    end
                end
                PF_XFER: begin
                    if (word_wr) begin
                        remain <= remain - LVL_W'(1);
                        if (remain == LVL_W'(1)) st <= PF_IDLE;
                    end
                end
                default: st <= PF_IDLE;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_len) && $stable(req_addr)); // R6
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_valid); // R6
    AST_NO_REQ_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PF_XFER) |-> !req_valid); // R7
    AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_len != '0); // R5
    AST_LEN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PF_IDLE) |-> calc_len <= DEPTH_L - fifo_level); // R3
    AST_LEN_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> FLEN_W'(req_len) <= frm_left); // R8
endmodule

// File: tb/pixfetch_req_test.sv
module pixfetch_req_test;
    localparam int DEPTH = 16;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int FLEN  = 23;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LVL_W-1:0]  fifo_level = LVL_W'(DEPTH);
    logic              mode_fixed = 1'b1;
    logic [LVL_W-1:0]  high_mark = '0;
    logic [LVL_W-1:0]  trig_mark = '0;
    logic [15:0]       frame_base = 16'h1200;
    logic [15:0]       frame_len = 16'(FLEN);
    logic              req_ready = 1'b0;
    logic              word_wr = 1'b0;
    logic              req_valid;
    logic [LVL_W-1:0]  req_len;
    logic [15:0]       req_addr;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int m_addr;
    int m_left;

    always #4 clk = ~clk;

    pixfetch_req #(.DEPTH(DEPTH), .ADDR_W(16), .FLEN_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .mode_fixed(mode_fixed),
        .high_mark(high_mark), .trig_mark(trig_mark), .frame_base(frame_base),
        .frame_len(frame_len), .req_ready(req_ready), .word_wr(word_wr),
        .req_valid(req_valid), .req_len(req_len), .req_addr(req_addr)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected length from the requirements (R3, R4, R5).
    function automatic int exp_len(int lvl, bit fx, int hm, int left);
        int free_w = DEPTH - lvl;
        int raw;
        int keep;
        if (fx) raw = (hm < free_w) ? hm : free_w;
        else begin
            keep = (hm >= 2) ? hm - 2 : 0;
            raw = (free_w > keep) ? free_w - keep : 0;
        end
        if (left < raw) raw = left;
        return raw;
    endfunction

    // Address model for R8.
    task automatic model_step();
        if (m_left == 1) begin
            m_addr = int'(frame_base);
            m_left = FLEN;
        end else begin
            m_addr = (m_addr + 1) & 16'hFFFF;
            m_left--;
        end
    endtask

    task automatic do_burst(input int lvl, input bit fx, input int hm, input int tm, input string tag);
        int e;
        @(negedge clk);
        fifo_level = LVL_W'(lvl);
        mode_fixed = fx;
        high_mark = LVL_W'(hm);
        trig_mark = LVL_W'(tm);
        e = (lvl <= tm) ? exp_len(lvl, fx, hm, m_left) : 0;
        @(negedge clk);
        fifo_level = LVL_W'(DEPTH);
        if (e == 0) begin
            chk(int'(req_valid), 0, {tag, " R2/R5 no request"});
            repeat (2) begin
                @(negedge clk);
                chk(int'(req_valid), 0, {tag, " R5 stays idle"});
            end
            return;
        end
        chk(int'(req_valid), 1, {tag, " R2 request raised"});
        chk(int'(req_len), e, {tag, fx ? " R3 fixed length" : " R4 dynamic length"});
        chk(int'(req_addr), m_addr, {tag, " R8 address"});
        repeat ($urandom % 3) begin
            @(negedge clk);
            chk(int'(req_valid), 1, {tag, " R6 held"});
            chk(int'(req_len), e, {tag, " R6 len held"});
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk(int'(req_valid), 0, {tag, " R6 drop after accept"});
        fifo_level = '0;
        for (int i = 0; i < e; i++) begin
            repeat ($urandom % 3) begin
                @(negedge clk);
                chk(int'(req_valid), 0, {tag, " R7 single outstanding"});
            end
            word_wr = 1'b1;
            if (i == e - 1) fifo_level = LVL_W'(DEPTH);
            @(negedge clk);
            word_wr = 1'b0;
            model_step();
            chk(int'(req_valid), 0, {tag, " R7 no request mid-burst"});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_addr = int'(frame_base);
        m_left = FLEN;
        @(negedge clk);
        chk(int'(req_valid), 0, "R1 reset idle");
        // R1: first request uses the frame base.
        do_burst(2, 1, 4, 8, "R1 first");
        // R2: level above trigger gives no request.
        do_burst(9, 1, 4, 8, "R2 above trigger");
        do_burst(8, 1, 4, 8, "R2 at trigger");
        // R3: fixed length clamped to the free space.
        do_burst(14, 1, 10, 15, "R3 clamp free");
        // R4: dynamic with high mark 2 fills to full; high mark 0 too.
        do_burst(3, 0, 2, 8, "R4 hm2");
        do_burst(5, 0, 0, 8, "R4 hm0");
        // R5: dynamic length zero and fixed high mark zero.
        do_burst(6, 0, 12, 8, "R5 dyn zero");
        do_burst(1, 1, 0, 8, "R5 fixed zero");
        // R7: stray word pulses while idle do not move the address.
        repeat (3) begin
            @(negedge clk); word_wr = 1'b1;
            @(negedge clk); word_wr = 1'b0;
        end
        do_burst(0, 1, 3, 4, "R7 idle words ignored");
        // R8: a new frame base is picked up at the next wrap.
        frame_base = 16'h4000;
        for (int k = 0; k < 6; k++) do_burst(0, 1, 8, 4, "R8 base change");
        for (int k = 0; k < 300; k++)
            do_burst(int'($urandom % (DEPTH + 1)), 1'($urandom % 2),
                     int'($urandom % (DEPTH + 1)), int'($urandom % (DEPTH + 1)), "random");
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule